// File: doc/BRIEF.md
# I2C Control Register Bank with Frame-Synchronous Commit

This block is a write-only I2C slave that holds a bank of twenty-one 8-bit control registers for a video window controller. A host sends a START, the device write byte, a register index and then any number of data bytes; the index advances after each data byte. Indices 15h to 18h are reserved: they are accepted on the bus and their data is dropped. The block answers no read requests.

Every byte written lands in a staging copy. Registers that only position or tune the acquisition pass straight from staging to the output bus. Registers that shape the visible picture (window enables and mode, scale factors, pixel expansion, window placement, colours, priority and border widths) have a second, active copy. That copy takes the whole staged set in one clock, on the selected edge of the main vertical sync, and only while the hold flag in staging is clear. Software can therefore set the hold flag, rewrite a whole layout over several frames, clear the flag and see the change land at one frame boundary.

Top module: `i2c_shadow_regbank`

## Requirements
- R1: Only the device write byte 58h (7-bit address 2Ch, direction bit 0) is acknowledged. Any other first byte, including the read byte 59h, gets no acknowledge, and later bytes are ignored and not acknowledged until the next START.
- R2: A START (SDA falling while SCL is high) begins a new address phase at any point, including a repeated START. A STOP (SDA rising while SCL is high) ends the transfer and releases SDA.
- R3: For each accepted byte (device byte, index, data), SDA is pulled low from the SCL fall after the eighth bit until the SCL fall after the ninth clock. Otherwise SDA is released.
- R4: The index advances by one after each data byte and stays at 18h once it gets there.
- R5: Data bytes at indices 15h and above are acknowledged and change no output.
- R6: Unused bits are stored as zero: all of 06h and 07h, bit 7 of 0Eh, and bits 7:6 of 0Fh and 14h.
- R7: Unheld registers (06h to 0Ch and 0Fh) show a written value on the output without waiting for a vertical sync, and hold flags do not affect them.
- R8: Held registers (00h to 05h, 0Dh, 0Eh, 10h to 14h) change on the output only on an active vertical sync edge. At that edge all of them take their staged values together.
- R9: While the staged hold flag (10h bit 7) is 1, active vertical sync edges transfer nothing. The first active edge after it returns to 0 transfers the whole staged set.
- R10: Register 0Ah bit 6 selects the active vertical sync edge: 0 means the rising edge, 1 means the falling edge. The other edge has no effect.
- R11: After reset, staging and active registers are all zero, except 14h, which is 12h (bits 5:3 vertical border = 2 lines, bits 2:0 horizontal border = 2 steps of two pixels).
- R12: SCL, SDA and vertical sync each pass through two flip-flops. A held register changes on the third clock edge after the vertical sync pin edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| vsync_i | input | 1 | Main-channel vertical sync |
| active_o | output | 168 | Register n on bits [8n+7:8n], for n = 0 to 20 |

## Verification
An unheld register shows its new value three clocks after the SCL fall that ends its eighth data bit. The acknowledge drive also starts about three clocks after that fall. The bench therefore keeps SCL at least eight clocks in each phase and reads the acknowledge halfway through the ninth high phase. A held register changes on the third clock edge after the vertical sync pin edge. The bench drives that pin just after an edge, checks that the old value still stands two edges later, and checks for the new value one edge after that. All other comparisons against the model happen after a STOP or some clocks after a sync change, once the output is settled.

// File: rtl/i2c_shadow_regbank.sv
module i2c_shadow_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int NUM_REGS = 21,
  parameter logic [7:0] LAST_SUB = 8'h18,
  parameter logic [20:0] HELD_MASK = 21'h1F603F,
  parameter int HOLD_REG = 16,
  parameter int HOLD_BIT = 7,
  parameter int POL_REG = 10,
  parameter int POL_BIT = 6,
  parameter int BORDER_REG = 20,
  parameter logic [7:0] BORDER_DEFAULT = 8'h12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic                  vsync_i,
  output logic [NUM_REGS*8-1:0] active_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_SUB, S_DATA} st_t;

  function automatic logic [7:0] used_bits(input logic [7:0] idx);
    case (idx)
      8'h06, 8'h07: used_bits = 8'h00;
      8'h0E:        used_bits = 8'h7F;
      8'h0F, 8'h14: used_bits = 8'h3F;
      default:      used_bits = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reset_val(input int idx);
    reset_val = (idx == BORDER_REG) ? BORDER_DEFAULT : 8'h00;
  endfunction

  logic [1:0] scl_q, sda_q, vs_q;
  logic       scl_p, sda_p, vs_p;
  logic       scl_s, sda_s, vs_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; vs_q <= 2'b00;
      scl_p <= 1'b1;  sda_p <= 1'b1;  vs_p <= 1'b0;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      vs_q  <= {vs_q[0], vsync_i};
      scl_p <= scl_q[1];
      sda_p <= sda_q[1];
      vs_p  <= vs_q[1];
    end

  assign scl_s = scl_q[1];
  assign sda_s = sda_q[1];
  assign vs_s  = vs_q[1];

  logic start_c, stop_c, scl_rise, scl_fall;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;

  st_t        state;
  logic [7:0] shreg, ptr;
  logic [3:0] bitcnt;
  logic       ackph, ack_ok, byte_done, data_wr, wr_en;

  assign ack_ok    = (state == S_ADDR) ? (shreg == {DEV_ADDR, 1'b0}) : (state != S_IDLE);
  assign byte_done = scl_fall && bitcnt == 4'd8 && !ackph && state != S_IDLE;
  assign data_wr   = byte_done && state == S_DATA;
  assign wr_en     = data_wr && ptr < 8'(NUM_REGS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; shreg <= '0; ptr <= '0; bitcnt <= '0;
      ackph <= 1'b0; sda_pull_o <= 1'b0;
    end else if (start_c) begin
      state <= S_ADDR; bitcnt <= '0; ackph <= 1'b0; sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; bitcnt <= '0; ackph <= 1'b0; sda_pull_o <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
      if (byte_done) begin
        ackph      <= 1'b1;
        sda_pull_o <= ack_ok;
        case (state)
          S_ADDR: if (ack_ok) state <= S_SUB;
          S_SUB:  begin ptr <= shreg; state <= S_DATA; end
          S_DATA: if (ptr < LAST_SUB) ptr <= ptr + 8'd1;
          default: ;
        endcase
      end else if (scl_fall && ackph) begin
        ackph      <= 1'b0;
        sda_pull_o <= 1'b0;
        bitcnt     <= '0;
        if (!ack_ok) state <= S_IDLE;
      end
    end

  logic [7:0] stage [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) stage[i] <= reset_val(i);
    end else if (wr_en) begin
      stage[ptr[IDX_W-1:0]] <= shreg & used_bits(ptr);
    end

  logic hold_now, vs_edge, commit;
  assign hold_now = stage[HOLD_REG][HOLD_BIT];
  assign vs_edge  = stage[POL_REG][POL_BIT] ? (vs_p & ~vs_s) : (vs_s & ~vs_p);
  assign commit   = vs_edge & ~hold_now;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (HELD_MASK[gi]) begin : g_held
      logic [7:0] act_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      act_q <= reset_val(gi);
        else if (commit) act_q <= stage[gi];
      assign active_o[gi*8 +: 8] = act_q;
    end else begin : g_direct
      assign active_o[gi*8 +: 8] = stage[gi];
    end
  end
endmodule

// File: rtl/i2c_shadow_regbank_sva.sv
module i2c_shadow_regbank_sva #(
  parameter int NUM_REGS = 21,
  parameter logic [20:0] HELD_MASK = 21'h1F603F,
  parameter logic [7:0] LAST_SUB = 8'h18
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  stop_c,
  input logic                  sda_pull_o,
  input logic                  vs_edge,
  input logic                  hold_now,
  input logic                  data_wr,
  input logic [7:0]            ptr,
  input logic [NUM_REGS*8-1:0] active_o
);
  localparam int OUT_W = NUM_REGS*8;

  function automatic logic [OUT_W-1:0] held_bits();
    logic [OUT_W-1:0] m = '0;
    for (int i = 0; i < NUM_REGS; i++) if (HELD_MASK[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [OUT_W-1:0] spare_bits();
    logic [OUT_W-1:0] m = '0;
    m[6*8 +: 8]  = 8'hFF;
    m[7*8 +: 8]  = 8'hFF;
    m[14*8 + 7]  = 1'b1;
    m[15*8 +: 8] = 8'hC0;
    m[20*8 +: 8] = 8'hC0;
    return m;
  endfunction

  localparam logic [OUT_W-1:0] HELD_BITS  = held_bits();
  localparam logic [OUT_W-1:0] SPARE_BITS = spare_bits();

  assert_held_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(vs_edge && !hold_now) |=> $stable(active_o & HELD_BITS));

  assert_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o & SPARE_BITS) == '0);

  assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pull_o);

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr < LAST_SUB) |=> ptr == $past(ptr) + 8'd1);

  assert_index_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr >= LAST_SUB) |=> ptr == $past(ptr));
endmodule

bind i2c_shadow_regbank i2c_shadow_regbank_sva #(
  .NUM_REGS(NUM_REGS), .HELD_MASK(HELD_MASK), .LAST_SUB(LAST_SUB)
) u_sva (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_c(stop_c),
  .sda_pull_o(sda_pull_o), .vs_edge(vs_edge), .hold_now(hold_now),
  .data_wr(data_wr), .ptr(ptr), .active_o(active_o)
);

// File: tb/i2c_shadow_regbank_bench.sv
module i2c_shadow_regbank_bench;
  localparam int N = 21;
  localparam int H = 8;
  localparam logic [20:0] HELD = 21'h1F603F;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1, vs = 1'b0;
  logic pull;
  logic [N*8-1:0] act;
  wire  sda_line = sda_drv & ~pull;

  always #5 clk = ~clk;

  i2c_shadow_regbank u_i2c_shadow_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .vsync_i(vs), .active_o(act));

  int checks = 0, errors = 0;
  logic [7:0] m_stage [N];
  logic [7:0] m_act [N];

  function automatic logic [7:0] used(input int i);
    case (i)
      6, 7:   used = 8'h00;
      14:     used = 8'h7F;
      15, 20: used = 8'h3F;
      default: used = 8'hFF;
    endcase
  endfunction

  function automatic logic [N*8-1:0] expect_vec();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = HELD[i] ? m_act[i] : m_stage[i];
    return v;
  endfunction

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_vec(input string tag, input logic [N*8-1:0] got, input logic [N*8-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wc(H); scl = 1'b1; wc(H); sda_drv = 1'b0; wc(H); scl = 1'b0; wc(2);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wc(H); scl = 1'b1; wc(H); sda_drv = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wc(H); scl = 1'b1; wc(H); scl = 1'b0; wc(2);
    end
    sda_drv = 1'b1; wc(H); scl = 1'b1; wc(H/2);
    ackd = ~sda_line;
    wc(H/2); scl = 1'b0; wc(4);
  endtask

  task automatic model_vs(input logic lvl);
    logic active_edge;
    active_edge = (lvl != vs) && (m_stage[10][6] ? !lvl : lvl);
    if (active_edge && !m_stage[16][7])
      for (int i = 0; i < N; i++) if (HELD[i]) m_act[i] = m_stage[i];
  endtask

  task automatic vs_drive(input logic lvl);
    model_vs(lvl);
    vs = lvl;
    wc(6);
  endtask

  task automatic write_txn(input logic [7:0] sub, input int len, input logic [31:0] data);
    logic a;
    logic [7:0] p;
    p = sub;
    i2c_start();
    send_byte(8'h58, a); check_bit("R1 device byte ack", a, 1'b1);
    send_byte(sub, a);   check_bit("R3 index ack", a, 1'b1);
    for (int k = 0; k < len; k++) begin
      send_byte(data[k*8 +: 8], a);
      check_bit(p >= 8'h15 ? "R5 reserved ack" : "R3 data ack", a, 1'b1);
      if (p < 8'(N)) m_stage[p] = data[k*8 +: 8] & used(int'(p));
      if (p < 8'h18) p = p + 8'd1;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [N*8-1:0] snap;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      m_stage[i] = (i == 20) ? 8'h12 : 8'h00;
      m_act[i]   = m_stage[i];
    end
    wc(4); rst_n = 1'b1; wc(4);

    check_vec("R11 reset defaults", act, expect_vec());
    check_vec("R11 border default 12h", {160'd0, act[20*8 +: 8]}, {160'd0, 8'h12});
    check_bit("R2 released after reset", pull, 1'b0);

    write_txn(8'h08, 1, 32'hA5);
    write_txn(8'h01, 1, 32'h3C);
    check_vec("R7 unheld immediate, R8 held waits", act, expect_vec());
    snap = act;
    model_vs(1'b1);
    vs = 1'b1; wc(2);
    check_vec("R12 still old two edges after sync", act, snap);
    wc(1);
    check_vec("R8 commit on third edge", act, expect_vec());
    vs_drive(1'b0);
    check_vec("R10 falling edge inert at polarity 0", act, expect_vec());

    write_txn(8'h0E, 2, 32'hFFFF);
    write_txn(8'h06, 2, 32'hFFFF);
    write_txn(8'h14, 1, 32'hFF);
    vs_drive(1'b1); vs_drive(1'b0);
    check_vec("R6 unused bits zero", act, expect_vec());

    write_txn(8'h10, 1, 32'h80);
    write_txn(8'h02, 1, 32'h77);
    write_txn(8'h0B, 1, 32'h5A);
    vs_drive(1'b1);
    check_vec("R9 no transfer while held, R7 unheld moves", act, expect_vec());
    vs_drive(1'b0);
    write_txn(8'h10, 1, 32'h00);
    check_vec("R9 still waiting for sync", act, expect_vec());
    vs_drive(1'b1);
    check_vec("R9 transfer after release", act, expect_vec());

    write_txn(8'h0A, 1, 32'h40);
    write_txn(8'h03, 1, 32'h11);
    vs_drive(1'b0);
    check_vec("R10 falling edge commits at polarity 1", act, expect_vec());
    write_txn(8'h04, 1, 32'h22);
    vs_drive(1'b1);
    check_vec("R10 rising edge inert at polarity 1", act, expect_vec());
    vs_drive(1'b0);

    write_txn(8'h12, 4, 32'hDDCCBBAA);
    vs_drive(1'b1); vs_drive(1'b0);
    check_vec("R5 reserved discarded, R4 increment", act, expect_vec());
    write_txn(8'h16, 4, 32'h44332211);
    write_txn(8'h1A, 2, 32'h9999);
    vs_drive(1'b1); vs_drive(1'b0);
    check_vec("R4 saturation at 18h, R5", act, expect_vec());

    snap = act;
    i2c_start();
    send_byte(8'h5A, a); check_bit("R1 foreign address nack", a, 1'b0);
    send_byte(8'h0B, a); check_bit("R1 ignored after nack", a, 1'b0);
    send_byte(8'h99, a); check_bit("R1 ignored data", a, 1'b0);
    i2c_stop();
    i2c_start();
    send_byte(8'h59, a); check_bit("R1 read byte nack", a, 1'b0);
    i2c_stop();
    check_vec("R1 nothing written", act, snap);

    i2c_start();
    send_byte(8'h58, a); send_byte(8'h0B, a); send_byte(8'h01, a);
    m_stage[11] = 8'h01;
    i2c_start();
    send_byte(8'h58, a); check_bit("R2 repeated start readdress", a, 1'b1);
    send_byte(8'h0C, a); send_byte(8'h02, a);
    m_stage[12] = 8'h02;
    i2c_stop();
    check_bit("R2 released after stop", pull, 1'b0);
    check_vec("R2 repeated start writes", act, expect_vec());

    for (int t = 0; t < 40; t++) begin
      logic [7:0] sub;
      int len;
      sub = 8'($urandom_range(0, 26));
      len = int'($urandom_range(1, 4));
      write_txn(sub, len, $urandom());
      check_vec("R7 R8 random write", act, expect_vec());
      vs_drive(1'($urandom_range(0, 1)));
      check_vec("R8 R9 R10 random sync", act, expect_vec());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule